// File: doc/BRIEF.md
# Microcode Patch Overlay

The overlay sits between a microcode sequencer and its microcode ROM. It holds a bank of patch entries. Each entry pairs a replacement microinstruction word with the ROM address that word overrides. On every fetch, the overlay forms the ROM address and compares it against every valid entry at once. One cycle later, when the ROM data arrives, the overlay passes on either the ROM word or the patched word, and flags which one it chose.

Entries are loaded by a push. A push writes the entry selected by an internal pointer, marks that entry valid, and advances the pointer. The pointer starts at entry 0 after reset and stops once the bank is full; it never wraps.

An execute-extension request overrides the sequencer address and forces the fetch to the fixed ROM address 0xF80. That fetch is still subject to patching.

Top module: `ucode_patch_overlay`

## Requirements
- R1: After reset, out_valid_o, hit_o and full_o are 0, and no entry is valid, so every fetch returns the ROM word.
- R2: rom_addr_o equals 0xF80 whenever ext_req_i is 1, and equals seq_addr_i otherwise, in the same cycle.
- R3: out_valid_o is 1 exactly in the cycle after a cycle in which fetch_valid_i was 1. In that cycle, uinst_o is formed alongside rom_data_i.
- R4: When the fetch address matches the 12-bit address of a valid entry, uinst_o is that entry's 256-bit word and hit_o is 1.
- R5: When no valid entry matches, uinst_o equals rom_data_i and hit_o is 0.
- R6: Each accepted push writes its address and word into the entry selected by the pointer, which is 0 after reset. It sets that entry valid and then adds one to the pointer.
- R7: When several valid entries hold the fetch address, the entry with the lowest index supplies the word.
- R8: A push issued in the same cycle as a fetch of the address being pushed does not affect that fetch. It does affect a fetch issued in the next cycle.
- R9: After 32 accepted pushes, full_o is 1. Later pushes change no entry and do not wrap the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Load one patch entry at the pointer |
| push_addr_i | input | 12 | ROM address the pushed entry overrides |
| push_word_i | input | 256 | Replacement microinstruction word |
| fetch_valid_i | input | 1 | Fetch request this cycle |
| seq_addr_i | input | 12 | Sequencer fetch address |
| ext_req_i | input | 1 | Force the fetch to the extension entry address |
| rom_addr_o | output | 12 | Address presented to the ROM |
| rom_data_i | input | 256 | ROM word, one cycle after the fetch |
| uinst_o | output | 256 | Delivered microinstruction word |
| hit_o | output | 1 | uinst_o came from a patch entry |
| out_valid_o | output | 1 | uinst_o is valid this cycle |
| full_o | output | 1 | All entries loaded; pushes ignored |

## Verification
A pointer that advances wrongly shows up on the first fetch of a later-pushed address. It either misses or returns the neighbouring entry's word, one cycle after the fetch. Stale or spurious valid bits show up the same way: ROM words are replaced where no patch was loaded, or patches are dropped. Priority faults are exposed by a pair of duplicate addresses. Saturation faults are exposed by a push after the bank is full, followed by fetches of both the new address and entry 0's address.

// File: rtl/upo_pkg.sv
package upo_pkg;
  localparam int unsigned DEF_ENTRIES = 32;
  localparam int unsigned DEF_WORD_W  = 256;
  localparam int unsigned DEF_ADDR_W  = 12;
  localparam logic [DEF_ADDR_W-1:0] DEF_EXT_ADDR = 12'hF80;
endpackage

// File: rtl/upo_fetch_sel.sv
module upo_fetch_sel #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EXT_ADDR = '0
) (
  input  logic              ext_req_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = ext_req_i ? EXT_ADDR : seq_addr_i;
endmodule

// File: rtl/upo_entry_bank.sv
module upo_entry_bank #(
  parameter int unsigned N      = 32,
  parameter int unsigned WORD_W = 256,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned PTR_W = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [N-1:0]      valid_o,
  output logic [ADDR_W-1:0] addr_o [N],
  output logic              full_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [N-1:0]      valid_q;
  logic [WORD_W-1:0] words_q [N];
  logic [ADDR_W-1:0] addrs_q [N];
  logic [IDX_W-1:0]  wr_idx;
  logic              push_en;

  assign full_o  = (ptr_q == PTR_W'(N));
  assign push_en = push_i && !full_o;
  assign wr_idx  = ptr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      valid_q <= '0;
    end else if (push_en) begin
      ptr_q           <= ptr_q + 1'b1;
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // payload storage needs no reset; valid_q gates its use
  always_ff @(posedge clk_i) begin
    if (push_en) begin
      words_q[wr_idx] <= push_word_i;
      addrs_q[wr_idx] <= push_addr_i;
    end
  end

  assign valid_o   = valid_q;
  assign addr_o    = addrs_q;
  assign rd_word_o = words_q[rd_idx_i];

  assert_push_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_en |=> ptr_q == PTR_W'($past(ptr_q) + 1'b1));
  assert_push_sets_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_en |=> valid_q[$past(wr_idx)]);
  assert_sat_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i) |=> ($stable(ptr_q) && $stable(valid_q)));
endmodule

// File: rtl/upo_match.sv
module upo_match #(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      valid_i,
  input  logic [ADDR_W-1:0] addr_i [N],
  input  logic [ADDR_W-1:0] key_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [N-1:0] match_v;
  logic [N-1:0] grant;
  logic [N-1:0] low_mask;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_v[g] = valid_i[g] && (addr_i[g] == key_i);
  end

  // lowest index wins
  assign grant = match_v & (~match_v + 1'b1);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_v[i]) idx_o = IDX_W'(i);
    end
  end

  assign hit_o    = |match_v;
  assign low_mask = (N'(1) << idx_o) - 1'b1;

  assert_grant_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_lowest_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_v & low_mask) == '0) && grant[idx_o]);
endmodule

// File: rtl/ucode_patch_overlay.sv
module ucode_patch_overlay
  import upo_pkg::*;
#(
  parameter int unsigned N      = DEF_ENTRIES,
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] EXT_ADDR = DEF_EXT_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [WORD_W-1:0] push_word_i,
  input  logic              fetch_valid_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic              ext_req_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  input  logic [WORD_W-1:0] rom_data_i,
  output logic [WORD_W-1:0] uinst_o,
  output logic              hit_o,
  output logic              out_valid_o,
  output logic              full_o
);
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      ent_valid;
  logic [ADDR_W-1:0] ent_addr [N];
  logic [WORD_W-1:0] patch_word;
  logic              look_hit;
  logic [IDX_W-1:0]  look_idx;
  logic              vld_q, hit_q;
  logic [IDX_W-1:0]  idx_q;

  upo_fetch_sel #(.ADDR_W(ADDR_W), .EXT_ADDR(EXT_ADDR)) u_sel (
    .ext_req_i (ext_req_i),
    .seq_addr_i(seq_addr_i),
    .addr_o    (rom_addr_o)
  );

  upo_entry_bank #(.N(N), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_i),
    .push_addr_i(push_addr_i),
    .push_word_i(push_word_i),
    .rd_idx_i   (idx_q),
    .rd_word_o  (patch_word),
    .valid_o    (ent_valid),
    .addr_o     (ent_addr),
    .full_o     (full_o)
  );

  upo_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(ent_valid),
    .addr_i (ent_addr),
    .key_i  (rom_addr_o),
    .hit_o  (look_hit),
    .idx_o  (look_idx)
  );

  // lookup registered to line up with the ROM read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= fetch_valid_i;
      hit_q <= fetch_valid_i && look_hit;
      if (fetch_valid_i) idx_q <= look_idx;
    end
  end

  // a hit entry is never rewritten (no wrap), so idx_q stays coherent
  assign uinst_o     = hit_q ? patch_word : rom_data_i;
  assign hit_o       = hit_q;
  assign out_valid_o = vld_q;

  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i |=> out_valid_o);
  assert_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> !out_valid_o);
  assert_hit_qual_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> out_valid_o);
  assert_ext_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_i |-> rom_addr_o == EXT_ADDR);
endmodule

// File: tb/ucode_patch_overlay_bench.sv
module ucode_patch_overlay_bench;
  localparam int AW = 12;
  localparam int WW = 256;
  localparam int NE = 32;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [WW-1:0] push_word_i = '0;
  logic          fetch_valid_i = 1'b0;
  logic [AW-1:0] seq_addr_i = '0;
  logic          ext_req_i = 1'b0;
  logic [AW-1:0] rom_addr_o;
  logic [WW-1:0] rom_data_i = '0;
  logic [WW-1:0] uinst_o;
  logic          hit_o, out_valid_o, full_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ucode_patch_overlay u_ucode_patch_overlay (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .push_addr_i(push_addr_i),
    .push_word_i(push_word_i), .fetch_valid_i(fetch_valid_i), .seq_addr_i(seq_addr_i),
    .ext_req_i(ext_req_i), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .uinst_o(uinst_o), .hit_o(hit_o), .out_valid_o(out_valid_o), .full_o(full_o)
  );

  // fetch vectors: seq address, ext request, expected ROM address, hit, entry
  localparam int V_ADDR [NV] = '{'h010, 'h020, 'h030, 'h030, 'h011, 'h000};
  localparam bit V_EXT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int V_RADR [NV] = '{'h010, 'h020, 'h030, 'hF80, 'h011, 'hF80};
  localparam bit V_HIT  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam int V_IDX  [NV] = '{0, 1, 0, 3, 0, 3};

  function automatic logic [WW-1:0] rom_word(input logic [AW-1:0] a);
    return {8{20'h3C3C3, a}};
  endfunction

  function automatic logic [WW-1:0] pat_word(input int k);
    return {8{32'hA500_0000 | 32'(k)}};
  endfunction

  task automatic check(input bit ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [WW-1:0] w);
    @(negedge clk);
    push_i = 1'b1; push_addr_i = a; push_word_i = w;
    @(posedge clk); #1;
    push_i = 1'b0;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input bit ext, input logic [AW-1:0] radr,
                       input bit exp_hit, input int exp_idx, input string req);
    logic [WW-1:0] exp_w;
    @(negedge clk);
    fetch_valid_i = 1'b1; seq_addr_i = a; ext_req_i = ext;
    #1 check(rom_addr_o == radr, "R2 rom address", WW'(rom_addr_o), WW'(radr));
    @(posedge clk); #1;
    fetch_valid_i = 1'b0; ext_req_i = 1'b0;
    rom_data_i = rom_word(radr);
    #1;
    exp_w = exp_hit ? pat_word(exp_idx) : rom_word(radr);
    check(out_valid_o == 1'b1, "R3 output valid", WW'(out_valid_o), WW'(1));
    check(hit_o == exp_hit, req, WW'(hit_o), WW'(exp_hit));
    check(uinst_o == exp_w, req, uinst_o, exp_w);
  endtask

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_ni = 1'b1;
    #1;
    // R1 reset state
    check(!out_valid_o && !hit_o && !full_o, "R1 reset outputs",
          WW'({out_valid_o, hit_o, full_o}), '0);
    fetch(12'h010, 1'b0, 12'h010, 1'b0, 0, "R1 empty bank misses");
    fetch(12'hF80, 1'b0, 12'hF80, 1'b0, 0, "R1 empty bank misses");

    // R6 fill in pointer order; entry 2 duplicates entry 0 for R7
    push(12'h010, pat_word(0));
    push(12'h020, pat_word(1));
    push(12'h010, pat_word(2));
    push(12'hF80, pat_word(3));

    for (int v = 0; v < NV; v++) begin
      fetch(AW'(V_ADDR[v]), V_EXT[v], AW'(V_RADR[v]), V_HIT[v], V_IDX[v],
            V_HIT[v] ? "R4 R6 R7 patched word" : "R5 ROM passthrough");
    end

    // R3 idle cycle yields no output
    @(negedge clk); fetch_valid_i = 1'b0;
    @(posedge clk); #1;
    check(!out_valid_o && !hit_o, "R3 idle no output", WW'({out_valid_o, hit_o}), '0);

    // R8 push and fetch of the same address in one cycle
    @(negedge clk);
    push_i = 1'b1; push_addr_i = 12'h040; push_word_i = pat_word(4);
    fetch_valid_i = 1'b1; seq_addr_i = 12'h040;
    @(posedge clk); #1;
    push_i = 1'b0; fetch_valid_i = 1'b0;
    rom_data_i = rom_word(12'h040); #1;
    check(!hit_o && uinst_o == rom_word(12'h040), "R8 same-cycle fetch misses",
          uinst_o, rom_word(12'h040));
    fetch(12'h040, 1'b0, 12'h040, 1'b1, 4, "R8 next fetch hits");

    // R9 fill remaining entries
    for (int k = 5; k < NE; k++) begin
      check(!full_o, "R9 not full early", WW'(full_o), '0);
      push(AW'(12'h100 + k), pat_word(k));
    end
    check(full_o, "R9 full after 32", WW'(full_o), WW'(1));
    fetch(AW'(12'h100 + NE - 1), 1'b0, AW'(12'h100 + NE - 1), 1'b1, NE - 1, "R9 last entry hits");
    push(12'h200, {8{32'h5A00_00FF}});
    push(12'h010, {8{32'h5A00_00FF}});
    check(full_o, "R9 stays full", WW'(full_o), WW'(1));
    fetch(12'h200, 1'b0, 12'h200, 1'b0, 0, "R9 push when full ignored");
    fetch(12'h010, 1'b0, 12'h010, 1'b1, 0, "R9 entry 0 not overwritten");
    fetch(12'h105, 1'b0, 12'h105, 1'b1, 5, "R6 mid entry intact");

    // R1 reset again clears entries
    @(negedge clk); rst_ni = 1'b0;
    #2 check(!out_valid_o && !full_o, "R1 reset clears", WW'({out_valid_o, full_o}), '0);
    @(negedge clk); rst_ni = 1'b1;
    fetch(12'h020, 1'b0, 12'h020, 1'b0, 0, "R1 entries invalid after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule